// File: doc/BRIEF.md
# Programmable-Priority Bus Arbiter with Parking

This block chooses which of up to sixteen masters may drive a shared local bus. The priority order is not fixed. A table of sixteen 4-bit slots, which software can rewrite, sets it. Each slot holds a master index. A lower slot number means a higher rank. The address-bus grant is registered. Once a master holds it, the master keeps it for as long as it requests. When no master requests, the grant can be parked on a chosen master, so that master can start a transfer without first arbitrating.

The block also issues a data-bus grant in answer to a transfer-start strobe. A control bit picks one of two timings. In the first, the grant appears in the same cycle as the strobe. In the second, it appears one cycle later. In both cases the grant is withheld while the data bus reports busy. Software reaches the slot table, the parking code and the timing bit through a small port with a write strobe, an address, write data and combinational read data.

Top module: `prio_park_arbiter`

## Requirements
- R1: Address 0 holds slots 0–7 and address 1 holds slots 8–15. Within each word, the lowest slot sits in bits [31:28] and each following slot takes the next lower nibble. Address 2 is the control word: the parking code is in bits [3:0] and the data-grant timing bit is bit 8. Address 3 reads as zero and ignores writes. Written values read back unchanged on `reg_rdata` in the cycle after the write.
- R2: During reset `gnt` and `dgnt` are zero. After reset, slot n holds n, so address 0 reads 0x01234567 and address 1 reads 0x89ABCDEF. The control word reads 0x00000002, which is parking code 2 with timing bit 0.
- R3: When the bus is not held, `gnt` changes in the cycle after `req` is sampled. It becomes one-hot on the requesting master that is named in the lowest-numbered slot.
- R4: If several slots name the same master, its lowest slot sets its rank. A master named in no slot is never granted in answer to a request.
- R5: A master that holds `gnt` and keeps its `req` asserted keeps the grant, even when a higher-ranked master requests.
- R6: If no master requests and the parking code is 0–3, then one cycle later `gnt` is one-hot on the master whose index equals the code.
- R7: If no master requests and the parking code is 4–15, then one cycle later `gnt` is all zeros.
- R8: At most one bit of `gnt` is set in any cycle.
- R9: With the timing bit at 0, `dgnt` is high in the same cycle as `ts` when `dbusy` is low.
- R10: With the timing bit at 1, `dgnt` is low in the cycle of `ts`. It is high in the following cycle if `dbusy` is low then. If the bus is busy, the grant waits until `dbusy` goes low.
- R11: `dgnt` is never high while `dbusy` is high. A strobe that arrives while the bus is busy is granted in the first cycle in which `dbusy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 16 | Bus request, one bit per master |
| gnt | output | 16 | Registered address-bus grant, one-hot or zero |
| ts | input | 1 | Transfer-start strobe from the current owner |
| dbusy | input | 1 | Data bus is occupied |
| dgnt | output | 1 | Data-bus grant |
| reg_we | input | 1 | Configuration write strobe |
| reg_addr | input | 2 | Configuration word select |
| reg_wdata | input | 32 | Configuration write data |
| reg_rdata | output | 32 | Configuration read data (combinational) |

## Verification
The data-grant properties assume that `ts` is a single-cycle pulse. They also assume that a new strobe is not raised while an earlier one is still waiting for the bus. The directed tasks always let each strobe be granted before issuing the next, and they keep `dbusy` steady within each case. The parking properties take the configuration as given in the cycle that `req` is idle. The tasks change the parking code only through the register port and then wait a cycle before they look at the grant. Priority cases separate each request pattern with an idle cycle under a reserved parking code, so every pattern is arbitrated from an empty bus and does not hit the hold rule.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

   // Bit of the control word that selects data-grant timing.
   localparam int unsigned PPA_DLY_BIT = 8;

   typedef enum logic {
      DG_SAME = 1'b0,
      DG_NEXT = 1'b1
   } dg_mode_e;

endpackage

// File: rtl/ppa_cfg_regs.sv
module ppa_cfg_regs
   import ppa_pkg::*;
#(
   parameter int N_MASTERS   = 16,
   parameter int IDX_W       = 4,
   parameter int REG_W       = 32,
   parameter int N_PRIO_REGS = 2,
   parameter int ADDR_W      = 2,
   parameter int PARK_RST    = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [REG_W-1:0]           wdata,
   output logic [REG_W-1:0]           rdata,
   output logic [N_MASTERS*IDX_W-1:0] slot_tab,
   output logic [IDX_W-1:0]           park_code,
   output dg_mode_e                   dly_mode
);
   localparam int SPR = REG_W / IDX_W;

   logic [REG_W-1:0] prio_q [N_PRIO_REGS];
   logic [IDX_W-1:0] park_q;
   dg_mode_e         dly_q;

   // Reset word: slot n holds n, lowest slot in the top nibble.
   function automatic logic [REG_W-1:0] prio_rst(int r);
      logic [REG_W-1:0] v;
      v = '0;
      for (int k = 0; k < SPR; k++)
         v[REG_W-1-k*IDX_W -: IDX_W] = IDX_W'(r*SPR + k);
      return v;
   endfunction

   for (genvar r = 0; r < N_PRIO_REGS; r++) begin : g_prio
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prio_q[r] <= prio_rst(r);
         else if (we && addr == ADDR_W'(r))
            prio_q[r] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         park_q <= IDX_W'(PARK_RST);
         dly_q  <= DG_SAME;
      end else if (we && addr == ADDR_W'(N_PRIO_REGS)) begin
         park_q <= wdata[IDX_W-1:0];
         dly_q  <= dg_mode_e'(wdata[PPA_DLY_BIT]);
      end
   end

   for (genvar s = 0; s < N_MASTERS; s++) begin : g_slot
      assign slot_tab[s*IDX_W +: IDX_W] =
         prio_q[s/SPR][REG_W-1-(s%SPR)*IDX_W -: IDX_W];
   end

   always_comb begin
      rdata = '0;
      for (int r = 0; r < N_PRIO_REGS; r++)
         if (addr == ADDR_W'(r)) rdata = prio_q[r];
      if (addr == ADDR_W'(N_PRIO_REGS)) begin
         rdata[IDX_W-1:0]   = park_q;
         rdata[PPA_DLY_BIT] = dly_q;
      end
   end

   assign park_code = park_q;
   assign dly_mode  = dly_q;
endmodule

// File: rtl/ppa_slot_select.sv
module ppa_slot_select #(
   parameter int N_MASTERS    = 16,
   parameter int IDX_W        = 4,
   parameter int N_PARK_CODES = 4
) (
   input  logic [N_MASTERS-1:0]       req,
   input  logic [N_MASTERS*IDX_W-1:0] slot_tab,
   input  logic [N_MASTERS-1:0]       gnt_q,
   input  logic [IDX_W-1:0]           park_code,
   output logic [N_MASTERS-1:0]       gnt_d
);
   localparam logic [N_MASTERS-1:0] ONE = N_MASTERS'(1);

   logic             hit;
   logic [IDX_W-1:0] win;
   logic [IDX_W-1:0] sidx;
   logic             hold;

   // Scan from the lowest rank upward so the lowest slot wins last.
   always_comb begin
      hit  = 1'b0;
      win  = '0;
      sidx = '0;
      for (int s = N_MASTERS-1; s >= 0; s--) begin
         sidx = slot_tab[s*IDX_W +: IDX_W];
         if (req[sidx]) begin
            hit = 1'b1;
            win = sidx;
         end
      end
   end

   assign hold = |(gnt_q & req);

   always_comb begin
      if (hold)
         gnt_d = gnt_q;
      else if (hit)
         gnt_d = ONE << win;
      else if (32'(park_code) < N_PARK_CODES)
         gnt_d = ONE << park_code;
      else
         gnt_d = '0;
   end
endmodule

// File: rtl/ppa_dgrant.sv
module ppa_dgrant
   import ppa_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  dg_mode_e dly_mode,
   input  logic     ts,
   input  logic     dbusy,
   output logic     dgnt
);
   logic pend_q;

   // A strobe waits in pend_q when delayed by mode or by a busy bus.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else
         pend_q <= (pend_q && dbusy) ||
                   (ts && (dly_mode == DG_NEXT || dbusy));
   end

   assign dgnt = !dbusy &&
                 (pend_q || (ts && dly_mode == DG_SAME));
endmodule

// File: rtl/prio_park_arbiter.sv
module prio_park_arbiter
   import ppa_pkg::*;
#(
   parameter  int N_MASTERS    = 16,
   parameter  int REG_W        = 32,
   parameter  int N_PARK_CODES = 4,
   parameter  int PARK_RST     = 2,
   localparam int IDX_W        = $clog2(N_MASTERS),
   localparam int SPR          = REG_W / IDX_W,
   localparam int N_PRIO_REGS  = N_MASTERS / SPR,
   localparam int ADDR_W       = $clog2(N_PRIO_REGS + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req,
   output logic [N_MASTERS-1:0] gnt,
   input  logic                 ts,
   input  logic                 dbusy,
   output logic                 dgnt,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata
);
   if (N_MASTERS != (1 << IDX_W)) begin : g_bad_masters
      $error("N_MASTERS must be a power of two");
   end
   if (REG_W % IDX_W != 0 || N_MASTERS % SPR != 0) begin : g_bad_reg
      $error("slot table must pack evenly into registers");
   end
   if (REG_W <= PPA_DLY_BIT || N_PARK_CODES > N_MASTERS) begin : g_bad_ctrl
      $error("control word layout does not fit");
   end
   if (PARK_RST >= N_MASTERS) begin : g_bad_park
      $error("PARK_RST out of range");
   end

   logic [N_MASTERS*IDX_W-1:0] slot_tab;
   logic [IDX_W-1:0]           park_code;
   dg_mode_e                   dly_mode;
   logic [N_MASTERS-1:0]       gnt_d;
   logic [N_MASTERS-1:0]       gnt_q;

   ppa_cfg_regs #(
      .N_MASTERS(N_MASTERS), .IDX_W(IDX_W), .REG_W(REG_W),
      .N_PRIO_REGS(N_PRIO_REGS), .ADDR_W(ADDR_W), .PARK_RST(PARK_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .slot_tab(slot_tab),
      .park_code(park_code), .dly_mode(dly_mode)
   );

   ppa_slot_select #(
      .N_MASTERS(N_MASTERS), .IDX_W(IDX_W), .N_PARK_CODES(N_PARK_CODES)
   ) u_sel (
      .req(req), .slot_tab(slot_tab), .gnt_q(gnt_q),
      .park_code(park_code), .gnt_d(gnt_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gnt_q <= '0;
      else        gnt_q <= gnt_d;
   end
   assign gnt = gnt_q;

   ppa_dgrant u_dg (
      .clk(clk), .rst_n(rst_n), .dly_mode(dly_mode),
      .ts(ts), .dbusy(dbusy), .dgnt(dgnt)
   );
endmodule

// File: rtl/ppa_checker.sv
module ppa_checker
   import ppa_pkg::*;
#(
   parameter int N_MASTERS    = 16,
   parameter int IDX_W        = 4,
   parameter int N_PARK_CODES = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_MASTERS-1:0] req,
   input logic [N_MASTERS-1:0] gnt,
   input logic                 ts,
   input logic                 dbusy,
   input logic                 dgnt,
   input logic [IDX_W-1:0]     park_code,
   input dg_mode_e             dly_mode
);
   localparam logic [N_MASTERS-1:0] ONE = N_MASTERS'(1);

   p_gnt_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   p_owner_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(gnt & req)) |=> (gnt == $past(gnt)));

   p_idle_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|req) && 32'(park_code) < N_PARK_CODES)
      |=> (gnt == (ONE << $past(park_code))));

   p_idle_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|req) && 32'(park_code) >= N_PARK_CODES) |=> (gnt == '0));

   p_dg_same_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_mode == DG_SAME && ts && !dbusy) |-> dgnt);

   p_dg_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_mode == DG_NEXT && ts) |=> (dgnt == !dbusy));

   p_busy_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dbusy |-> !dgnt);
endmodule

bind prio_park_arbiter ppa_checker #(
   .N_MASTERS(N_MASTERS), .IDX_W(IDX_W), .N_PARK_CODES(N_PARK_CODES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .ts(ts),
   .dbusy(dbusy), .dgnt(dgnt), .park_code(park_code), .dly_mode(dly_mode)
);

// File: tb/prio_park_arbiter_bench.sv
module prio_park_arbiter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] req = '0;
   logic [15:0] gnt;
   logic        ts = 1'b0;
   logic        dbusy = 1'b0;
   logic        dgnt;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int checks = 0;
   int errors = 0;
   logic [3:0] tbl [16];

   always #4 clk = ~clk;

   prio_park_arbiter u_prio_park_arbiter (
      .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .ts(ts),
      .dbusy(dbusy), .dgnt(dgnt), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic load_tbl();
      logic [31:0] w0, w1;
      w0 = '0; w1 = '0;
      for (int k = 0; k < 8; k++) begin
         w0[31-4*k -: 4] = tbl[k];
         w1[31-4*k -: 4] = tbl[k+8];
      end
      wr(2'd0, w0);
      wr(2'd1, w1);
   endtask

   function automatic logic [15:0] exp_win(logic [15:0] r);
      for (int s = 0; s < 16; s++)
         if (r[tbl[s]]) return 16'(1) << tbl[s];
      return '0;
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      rst_n = 1'b0;
      repeat (3) step();
      chk("R2 gnt in reset", 32'(gnt), 32'h0);
      chk("R2 dgnt in reset", 32'(dgnt), 32'h0);
      rst_n = 1'b1;
      rd(2'd0, d); chk("R2 slots 0-7 reset", d, 32'h01234567);
      rd(2'd1, d); chk("R2 slots 8-15 reset", d, 32'h89ABCDEF);
      rd(2'd2, d); chk("R2 control reset", d, 32'h00000002);
      step();
      chk("R2 idle park on master 2", 32'(gnt), 32'h4);
   endtask

   task automatic t_regmap();
      logic [31:0] d;
      wr(2'd0, 32'hFEDCBA98); rd(2'd0, d); chk("R1 word 0 readback", d, 32'hFEDCBA98);
      wr(2'd1, 32'h13579BDF); rd(2'd1, d); chk("R1 word 1 readback", d, 32'h13579BDF);
      wr(2'd2, 32'hFFFF_FFF1); rd(2'd2, d); chk("R1 control readback", d, 32'h00000101);
      wr(2'd3, 32'hDEADBEEF); rd(2'd3, d); chk("R1 address 3 reads zero", d, 32'h0);
      rd(2'd0, d); chk("R1 address 3 write ignored", d, 32'hFEDCBA98);
      wr(2'd2, 32'h2);
   endtask

   task automatic t_priority();
      logic [15:0] pats [4];
      wr(2'd2, 32'hF);
      for (int t = 0; t < 6; t++) begin
         for (int s = 0; s < 16; s++) tbl[s] = 4'($urandom);
         load_tbl();
         pats[0] = 16'($urandom); pats[1] = 16'hFFFF;
         pats[2] = 16'(1) << tbl[15]; pats[3] = 16'($urandom) & 16'($urandom);
         for (int p = 0; p < 4; p++) begin
            req = '0; step();
            req = pats[p]; step();
            chk("R3 table priority", 32'(gnt), 32'(exp_win(pats[p])));
         end
         req = '0; step();
      end
   endtask

   task automatic t_dup();
      for (int s = 0; s < 16; s++) tbl[s] = 4'd3;
      tbl[0] = 4'd9; tbl[2] = 4'd9;
      load_tbl();
      req = '0; step();
      req = 16'h0208; step();
      chk("R4 duplicate lowest slot", 32'(gnt), 32'h0200);
      req = '0; step();
      req = 16'h0002; step();
      chk("R4 unnamed master not granted", 32'(gnt), 32'h0);
      req = '0; wr(2'd2, 32'h1); step();
      chk("R4 unnamed master parked", 32'(gnt), 32'h0002);
      wr(2'd2, 32'hF); step();
   endtask

   task automatic t_hold();
      for (int s = 0; s < 16; s++) tbl[s] = 4'(s);
      load_tbl();
      req = '0; step();
      req = 16'h0020; step();
      chk("R5 first owner", 32'(gnt), 32'h0020);
      req = 16'h0021; step();
      chk("R5 no preemption", 32'(gnt), 32'h0020);
      step();
      chk("R8 single grant while held", 32'($countones(gnt)), 32'd1);
      req = 16'h0001; step();
      chk("R5 release passes grant", 32'(gnt), 32'h0001);
      req = '0; step();
   endtask

   task automatic t_park();
      for (int c = 0; c < 4; c++) begin
         wr(2'd2, 32'(c)); step();
         chk("R6 parked master", 32'(gnt), 32'(16'(1) << c));
      end
      wr(2'd2, 32'h4); step();
      chk("R7 reserved code 4", 32'(gnt), 32'h0);
      wr(2'd2, 32'hF); step();
      chk("R7 reserved code 15", 32'(gnt), 32'h0);
   endtask

   task automatic t_dly0();
      wr(2'd2, 32'h2);
      dbusy = 1'b0; ts = 1'b1;
      #1 chk("R9 same-cycle data grant", 32'(dgnt), 32'h1);
      step(); ts = 1'b0;
      #1 chk("R9 grant is one cycle", 32'(dgnt), 32'h0);
      step();
      dbusy = 1'b1; ts = 1'b1;
      #1 chk("R11 busy blocks grant", 32'(dgnt), 32'h0);
      step(); ts = 1'b0;
      #1 chk("R11 still busy", 32'(dgnt), 32'h0);
      step(); dbusy = 1'b0;
      #1 chk("R11 granted when free", 32'(dgnt), 32'h1);
      step();
      #1 chk("R11 grant cleared", 32'(dgnt), 32'h0);
   endtask

   task automatic t_dly1();
      wr(2'd2, 32'h102);
      dbusy = 1'b0; ts = 1'b1;
      #1 chk("R10 no grant with strobe", 32'(dgnt), 32'h0);
      step(); ts = 1'b0;
      #1 chk("R10 grant one cycle later", 32'(dgnt), 32'h1);
      step();
      #1 chk("R10 grant cleared", 32'(dgnt), 32'h0);
      ts = 1'b1;
      step(); ts = 1'b0; dbusy = 1'b1;
      #1 chk("R10 waits while busy", 32'(dgnt), 32'h0);
      step(); dbusy = 1'b0;
      #1 chk("R10 granted after busy", 32'(dgnt), 32'h1);
      step();
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_regmap();
      t_priority();
      t_dup();
      t_hold();
      t_park();
      t_dly0();
      t_dly1();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule